// File: doc/BRIEF.md
# Four-Beat Double-Rate Burst SRAM Core

This block is a synthesizable storage core with independent read and write request lines. Every transfer moves four consecutive words, and the data moves at twice the request rate. The core runs from one clock. Each rising edge of that clock is one phase of a virtual forward clock pair, and the phases alternate: a "K" phase, on which requests are taken, and a "K-bar" phase. Write data and per-lane byte masks are captured on both kinds of phase. Read data is presented on both kinds of phase.

The address selects a group of four words. A write burst captures four beats into that group in ascending word order. A read burst presents the four words of the group in the same order. Read data can follow the forward clock directly, when the output clock pair is tied high. It can also follow a separate output clock pair, which the model represents as a delay of one phase. The output has no tristate driver. A valid flag marks the phases on which read data is present, and a low flag stands for a floating bus.

Top module: `burst4_ddr_sram`

## Requirements
- R1: Requests are sampled only on K phases. The first rising clock edge after `rst_n` goes high is a K phase, and phases alternate from then on. A request held low only across a K-bar edge has no effect. An edge where both `rd_req_n` and `wr_req_n` are high produces no read data and changes no memory.
- R2: A write accepted on K edge p captures `wdata`/`be_n` on edges p+2, p+3, p+4 and p+5 into word offsets 0, 1, 2 and 3 of group `addr`.
- R3: With `oclk_held`=1, a read accepted on K edge p raises `rvalid` after edges p+3, p+4, p+5 and p+6. In those phases `rdata` carries word offsets 0, 1, 2 and 3 of the group, in that order.
- R4: With `oclk_held`=0, every read beat appears one edge later than in R3, after edges p+4 to p+7, in the same order.
- R5: A read request on the K edge right after an accepted read is dropped. The same holds for writes. The dropped request produces no beat and writes no word.
- R6: `be_n[i]` low lets that beat write bits 9*i to 9*i+8 of the word (lane 0 is bits 8:0, lane 3 is bits 35:27). A lane whose bit is high keeps its old contents.
- R7: Masks are taken separately for each beat. A beat with `be_n`=4'b1111 leaves its word unchanged.
- R8: `rvalid` is low whenever no read beat is presented, and it is low right after reset.
- R9: A read and a write may be accepted on the same K edge. When they do, the read returns the group as it was before that write. A read accepted on edge p sees every write beat captured before edge p+2.
- R10: Word offsets never wrap into another group. A burst to the last group leaves group 0 untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; every rising edge is one phase |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| rd_req_n | input | 1 | Active-low read request, sampled on K phases |
| wr_req_n | input | 1 | Active-low write request, sampled on K phases |
| addr | input | GRP_AW | Group address of the burst |
| oclk_held | input | 1 | 1: output clocks tied high, K timing; 0: output-clock timing |
| wdata | input | LANES*LANE_W | Write beat data |
| be_n | input | LANES | Active-low per-lane write enables for the current beat |
| rdata | output | LANES*LANE_W | Read beat data |
| rvalid | output | 1 | High while a read beat is presented (low = floating bus) |

## Verification
The assertions assume three things about the inputs: `rst_n` is released away from a rising clock edge, `oclk_held` stays steady while read beats are being presented, and write masks are meaningful only during a write burst. The bench releases reset on a falling edge. It changes `oclk_held` only at the start of a burst, after the previous burst's valid window has closed. It returns `be_n` to all-high between bursts. Every burst is launched so that the request lands on a K phase, except in the one test that deliberately places a request on a K-bar phase.

// File: rtl/b4s_pkg.sv
package b4s_pkg;
  localparam int unsigned BEATS  = 4;
  localparam int unsigned OFS_W  = $clog2(BEATS);
  localparam int unsigned CNT_W  = $clog2(BEATS + 1);

  typedef enum logic {
    PH_K  = 1'b0,
    PH_KB = 1'b1
  } phase_e;
endpackage

// File: rtl/b4s_req_gate.sv
module b4s_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic k_edge,
  input  logic req_n,
  output logic acc
);
  logic last_q, last_d;

  assign acc = k_edge & ~req_n & ~last_q;

  always_comb begin
    last_d = last_q;
    if (k_edge) last_d = acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= last_d;
  end

  // R1: acceptance only on K phases
  p_acc_on_k_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !k_edge |-> !acc);

  // R5: no acceptance on the next K edge after an acceptance
  p_no_repeat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !acc ##1 !acc);
endmodule

// File: rtl/b4s_mem.sv
module b4s_mem
  import b4s_pkg::*;
#(
  parameter int unsigned GRP_AW = 4,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [GRP_AW+OFS_W-1:0]       widx,
  input  logic [LANES*LANE_W-1:0]       wdata,
  input  logic [LANES-1:0]              be_n,
  input  logic [GRP_AW-1:0]             raddr,
  output logic [BEATS*LANES*LANE_W-1:0] rgrp
);
  localparam int unsigned W     = LANES * LANE_W;
  localparam int unsigned DEPTH = (1 << GRP_AW) * BEATS;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (!be_n[l]) mem_q[widx][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  for (genvar b = 0; b < BEATS; b++) begin : g_rd
    assign rgrp[b*W +: W] = mem_q[{raddr, OFS_W'(b)}];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    // R6: an enabled lane takes the beat's data
    p_lane_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we && !be_n[l] |=>
        mem_q[$past(widx)][l*LANE_W +: LANE_W] == $past(wdata[l*LANE_W +: LANE_W]));
  end

  // R7: a fully masked beat keeps the word
  p_masked_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we && (&be_n) |=> mem_q[$past(widx)] == $past(mem_q[widx]));
endmodule

// File: rtl/b4s_wr_seq.sv
module b4s_wr_seq
  import b4s_pkg::*;
#(
  parameter int unsigned GRP_AW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    k_edge,
  input  logic                    acc,
  input  logic [GRP_AW-1:0]       addr,
  output logic                    we,
  output logic [GRP_AW+OFS_W-1:0] widx
);
  logic              pend_q, pend_d;
  logic [GRP_AW-1:0] pa_q, pa_d, aa_q, aa_d;
  logic [OFS_W-1:0]  ofs_q, ofs_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              start;

  assign start = pend_q & k_edge;
  assign we    = start | (left_q != '0);
  assign widx  = start ? {pa_q, {OFS_W{1'b0}}} : {aa_q, ofs_q};

  always_comb begin
    pend_d = pend_q;
    pa_d   = pa_q;
    aa_d   = aa_q;
    ofs_d  = ofs_q;
    left_d = left_q;
    if (start) begin
      pend_d = 1'b0;
      aa_d   = pa_q;
      ofs_d  = OFS_W'(1);
      left_d = CNT_W'(BEATS - 1);
    end else if (left_q != '0) begin
      ofs_d  = ofs_q + OFS_W'(1);
      left_d = left_q - CNT_W'(1);
    end
    if (acc) begin
      pend_d = 1'b1;
      pa_d   = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      left_q <= '0;
      ofs_q  <= '0;
    end else begin
      pend_q <= pend_d;
      left_q <= left_d;
      ofs_q  <= ofs_d;
    end
  end

  always_ff @(posedge clk) begin
    pa_q <= pa_d;
    aa_q <= aa_d;
  end

  // R2: a started write runs exactly four consecutive beats
  p_wr_four_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> we ##1 we ##1 we);

  // R5: a new burst never starts over a running one
  p_wr_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> left_q == '0);
endmodule

// File: rtl/b4s_rd_seq.sv
module b4s_rd_seq
  import b4s_pkg::*;
#(
  parameter int unsigned GRP_AW = 4,
  parameter int unsigned W      = 36
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 k_edge,
  input  logic                 acc,
  input  logic [GRP_AW-1:0]    addr,
  input  logic                 oclk_held,
  input  logic [BEATS*W-1:0]   rgrp,
  output logic [GRP_AW-1:0]    raddr,
  output logic [W-1:0]         rdata,
  output logic                 rvalid
);
  logic              pend_q, pend_d;
  logic [GRP_AW-1:0] pa_q, pa_d;
  logic [BEATS*W-1:0] snap_q, snap_d;
  logic [OFS_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [W-1:0]      qk_q, qk_d, qc_q;
  logic              vk_q, vk_d, vc_q;
  logic              load;

  assign load  = pend_q & k_edge;
  assign raddr = pa_q;

  always_comb begin
    pend_d = pend_q;
    pa_d   = pa_q;
    snap_d = snap_q;
    idx_d  = idx_q;
    left_d = left_q;
    qk_d   = qk_q;
    vk_d   = 1'b0;
    if (left_q != '0) begin
      qk_d   = snap_q[W*int'(idx_q) +: W];
      vk_d   = 1'b1;
      idx_d  = idx_q + OFS_W'(1);
      left_d = left_q - CNT_W'(1);
    end
    if (load) begin
      pend_d = 1'b0;
      snap_d = rgrp;
      idx_d  = '0;
      left_d = CNT_W'(BEATS);
    end
    if (acc) begin
      pend_d = 1'b1;
      pa_d   = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      idx_q  <= '0;
      left_q <= '0;
      vk_q   <= 1'b0;
      vc_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      idx_q  <= idx_d;
      left_q <= left_d;
      vk_q   <= vk_d;
      vc_q   <= vk_q;
    end
  end

  always_ff @(posedge clk) begin
    pa_q   <= pa_d;
    snap_q <= snap_d;
    qk_q   <= qk_d;
    qc_q   <= qk_q;
  end

  assign rdata  = oclk_held ? qk_q : qc_q;
  assign rvalid = oclk_held ? vk_q : vc_q;

  // R3: a presented burst lasts four phases
  p_rd_four_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vk_q) |=> vk_q ##1 vk_q ##1 vk_q);

  // R5: a snapshot is only loaded at the last beat of the prior burst or later
  p_rd_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> left_q <= CNT_W'(1));

  // R4: output-clock timing trails forward timing by one phase
  p_c_trails_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vk_q) |=> $rose(vc_q));
endmodule

// File: rtl/burst4_ddr_sram.sv
module burst4_ddr_sram
  import b4s_pkg::*;
#(
  parameter int unsigned GRP_AW = 4,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_req_n,
  input  logic                     wr_req_n,
  input  logic [GRP_AW-1:0]        addr,
  input  logic                     oclk_held,
  input  logic [LANES*LANE_W-1:0]  wdata,
  input  logic [LANES-1:0]         be_n,
  output logic [LANES*LANE_W-1:0]  rdata,
  output logic                     rvalid
);
  localparam int unsigned W = LANES * LANE_W;

  phase_e ph_q, ph_d;
  logic   k_edge;
  logic   rd_acc, wr_acc;
  logic   we;
  logic [GRP_AW+OFS_W-1:0] widx;
  logic [GRP_AW-1:0]       raddr;
  logic [BEATS*W-1:0]      rgrp;

  assign k_edge = (ph_q == PH_K);

  always_comb begin
    ph_d = (ph_q == PH_K) ? PH_KB : PH_K;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_K;
    else        ph_q <= ph_d;
  end

  b4s_req_gate u_rd_gate (
    .clk(clk), .rst_n(rst_n), .k_edge(k_edge), .req_n(rd_req_n), .acc(rd_acc)
  );

  b4s_req_gate u_wr_gate (
    .clk(clk), .rst_n(rst_n), .k_edge(k_edge), .req_n(wr_req_n), .acc(wr_acc)
  );

  b4s_wr_seq #(.GRP_AW(GRP_AW)) u_wr_seq (
    .clk(clk), .rst_n(rst_n), .k_edge(k_edge), .acc(wr_acc), .addr(addr),
    .we(we), .widx(widx)
  );

  b4s_mem #(.GRP_AW(GRP_AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .wdata(wdata), .be_n(be_n),
    .raddr(raddr), .rgrp(rgrp)
  );

  b4s_rd_seq #(.GRP_AW(GRP_AW), .W(W)) u_rd_seq (
    .clk(clk), .rst_n(rst_n), .k_edge(k_edge), .acc(rd_acc), .addr(addr),
    .oclk_held(oclk_held), .rgrp(rgrp), .raddr(raddr),
    .rdata(rdata), .rvalid(rvalid)
  );

  // R8: bus floats right after reset
  p_hiz_reset_r8: assert property (@(posedge clk)
    $rose(rst_n) |-> !rvalid);

  // R4: output timing mode is not changed during a presented burst
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $stable(oclk_held));
endmodule

// File: tb/burst4_ddr_sram_tb.sv
module burst4_ddr_sram_tb;
  localparam time CLK_P = 4ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_req_n, wr_req_n, oclk_held;
  logic [3:0]  addr;
  logic [35:0] wdata;
  logic [3:0]  be_n;
  logic [35:0] rdata;
  logic        rvalid;
  logic        nxt_k;

  int n_run = 0;
  int n_fail = 0;
  logic [35:0] mdl [64];

  always #(CLK_P/2) clk = ~clk;

  // R1: phase tracking from the specification
  always @(posedge clk) begin
    if (!rst_n) nxt_k <= 1'b1;
    else        nxt_k <= ~nxt_k;
  end

  burst4_ddr_sram u_dut (
    .clk(clk), .rst_n(rst_n), .rd_req_n(rd_req_n), .wr_req_n(wr_req_n),
    .addr(addr), .oclk_held(oclk_held), .wdata(wdata), .be_n(be_n),
    .rdata(rdata), .rvalid(rvalid)
  );

  // vector: [28] held, [27:24] group, [23:16] seed, [15:0] masks (beat0 in [3:0]), [30:29] tag
  localparam logic [30:0] VEC [8] = '{
    {2'd0, 1'b1, 4'd3,  8'hA5, 16'h0000},
    {2'd1, 1'b0, 4'd3,  8'h3C, 16'h7BDE},
    {2'd1, 1'b1, 4'd7,  8'h5A, 16'hE7DB},
    {2'd2, 1'b0, 4'd7,  8'h11, 16'hF0F0},
    {2'd2, 1'b1, 4'd9,  8'hC3, 16'hFFFF},
    {2'd0, 1'b0, 4'd12, 8'h96, 16'h0000},
    {2'd1, 1'b1, 4'd12, 8'h0F, 16'h1248},
    {2'd2, 1'b0, 4'd1,  8'h77, 16'h0F0F}
  };

  function automatic string tag_of(input logic [1:0] c);
    case (c)
      2'd0:    return "R2";
      2'd1:    return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [35:0] gen(input logic [7:0] seed, input int b);
    logic [1:0] bb;
    bb = 2'(b);
    return {4{seed, 1'b1}} ^ {9{bb, ~bb}};
  endfunction

  function automatic logic [35:0] merge(input logic [35:0] o, input logic [35:0] n,
                                        input logic [3:0] m);
    logic [35:0] r;
    r = o;
    for (int l = 0; l < 4; l++) if (!m[l]) r[l*9 +: 9] = n[l*9 +: 9];
    return r;
  endfunction

  task automatic chk(input logic [35:0] act, input logic [35:0] exp, input string tg,
                     input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tg, what, act, exp);
    end
  endtask

  // One burst window: request on a K edge, ten falling edges observed.
  task automatic burst(input bit do_rd, input bit do_wr, input bit held, input bit rep,
                       input logic [3:0] a, input logic [3:0] a2,
                       input logic [7:0] seed, input logic [15:0] msk, input string tg);
    logic [35:0] exp_rd [4];
    int lat;
    @(negedge clk);
    while (!nxt_k) @(negedge clk);
    for (int b = 0; b < 4; b++) exp_rd[b] = mdl[{a, 2'(b)}];
    lat = held ? 3 : 4;
    rd_req_n  = !do_rd;
    wr_req_n  = !do_wr;
    addr      = a;
    oclk_held = held;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (do_rd && k > lat && k <= lat + 4) begin
        chk({35'd0, rvalid}, 36'd1, tg, "rvalid in beat");
        chk(rdata, exp_rd[k-lat-1], tg, "rdata beat");
      end else begin
        chk({35'd0, rvalid}, 36'd0, tg, "rvalid outside beats");
      end
      if (k == 1) begin rd_req_n = 1'b1; wr_req_n = 1'b1; end
      if (rep && k == 2) begin rd_req_n = !do_rd; wr_req_n = !do_wr; addr = a2; end
      if (k == 3) begin rd_req_n = 1'b1; wr_req_n = 1'b1; end
      if (do_wr && k >= 2 && k <= 5) begin
        wdata = gen(seed, k - 2);
        be_n  = msk[4*(k-2) +: 4];
      end
      if (k == 6) begin be_n = 4'hF; wdata = ~wdata; end
    end
    if (do_wr)
      for (int b = 0; b < 4; b++)
        mdl[{a, 2'(b)}] = merge(mdl[{a, 2'(b)}], gen(seed, b), msk[4*b +: 4]);
  endtask

  initial begin
    rst_n = 1'b0; rd_req_n = 1'b1; wr_req_n = 1'b1; oclk_held = 1'b1;
    addr = '0; wdata = '0; be_n = 4'hF;
    repeat (3) @(negedge clk);
    chk({35'd0, rvalid}, 36'd0, "R8", "rvalid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk({35'd0, rvalid}, 36'd0, "R8", "rvalid after reset");

    // fill every group (R2)
    for (int g = 0; g < 16; g++) begin
      for (int i = 0; i < 4; i++) mdl[{4'(g), 2'(i)}] = '0;
      burst(0, 1, 1, 0, 4'(g), 4'(g), 8'(g * 17 + 1), 16'h0000, "R2");
    end

    // no-operation window (R1), then confirm memory with a read
    burst(0, 0, 1, 0, 4'd5, 4'd5, 8'h00, 16'hFFFF, "R1");
    burst(1, 0, 1, 0, 4'd5, 4'd5, 8'h00, 16'hFFFF, "R1");

    // table walk: write with masks, then read back
    for (int v = 0; v < 8; v++) begin
      burst(0, 1, VEC[v][28], 0, VEC[v][27:24], VEC[v][27:24], VEC[v][23:16],
            VEC[v][15:0], tag_of(VEC[v][30:29]));
      burst(1, 0, VEC[v][28], 0, VEC[v][27:24], VEC[v][27:24], 8'h00, 16'hFFFF,
            VEC[v][28] ? "R3" : "R4");
    end

    // last group does not wrap into group 0 (R10)
    burst(0, 1, 1, 0, 4'd15, 4'd15, 8'hE1, 16'h0000, "R10");
    burst(1, 0, 0, 0, 4'd0,  4'd0,  8'h00, 16'hFFFF, "R10");
    burst(1, 0, 1, 0, 4'd15, 4'd15, 8'h00, 16'hFFFF, "R10");

    // same-edge read and write returns old contents (R9)
    burst(1, 1, 1, 0, 4'd6, 4'd6, 8'h4B, 16'h0000, "R9");
    burst(1, 0, 1, 0, 4'd6, 4'd6, 8'h00, 16'hFFFF, "R9");

    // repeated request on the next K edge is dropped (R5)
    burst(1, 0, 1, 1, 4'd2, 4'd8, 8'h00, 16'hFFFF, "R5");
    burst(1, 0, 0, 1, 4'd4, 4'd8, 8'h00, 16'hFFFF, "R5");
    burst(0, 1, 1, 1, 4'd10, 4'd11, 8'h9D, 16'h0000, "R5");
    burst(1, 0, 1, 0, 4'd11, 4'd11, 8'h00, 16'hFFFF, "R5");
    burst(1, 0, 1, 0, 4'd10, 4'd10, 8'h00, 16'hFFFF, "R5");

    // request held only across a K-bar edge is ignored (R1)
    @(negedge clk);
    while (nxt_k) @(negedge clk);
    rd_req_n = 1'b0; wr_req_n = 1'b0; addr = 4'd13;
    @(negedge clk);
    rd_req_n = 1'b1; wr_req_n = 1'b1;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      wdata = 36'hF_FFFF_FFFF; be_n = 4'h0;
    end
    be_n = 4'hF;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk({35'd0, rvalid}, 36'd0, "R1", "rvalid after K-bar request");
    end
    burst(1, 0, 1, 0, 4'd13, 4'd13, 8'h00, 16'hFFFF, "R1");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule